// File: doc/BRIEF.md
# Half-Width Trace Port Serializer

This block sits between an on-chip trace source and the trace data pins. It takes one full-width trace word per frame and drives it onto the pins together with a trace clock that it generates itself. The block is modelled on a fast clock. One frame lasts four fast-clock cycles, numbered 0 to 3. The generated trace clock and the data pins are laid out within a frame so that every edge of the trace clock falls in the middle of a period of stable data.

Three modes are available. In the full mode, the whole word is driven for the full frame and the trace clock makes one pulse per frame. In the split mode, only the lower half of the pins carries data, which halves the pin count. The lower half of the word is paired with the rising edge of the trace clock, and the upper half follows half a trace period later, paired with the falling edge. In the half-rate-clock mode, the whole word is driven as in the full mode, but the trace clock toggles only once per frame. Both of its edges then mark a word, so the word rate matches the full mode while the clock pin runs at half the frequency.

The word, its valid flag and the mode are captured together at the last edge of each frame. A word is therefore never split across two modes.

Top module: `trace_halfpin_ser`

## Requirements
- R1: While reset is held and after it is released, the trace clock output is low at frame cycle 0 and the data pins are all zero until the first captured valid word appears.
- R2: Frame cycle 0 begins at reset release. The inputs are sampled only at the 4th rising clock edge after release and at every 4th edge after that. A sampled word is driven from the following frame cycle 0.
- R3: Mode code 2'b00 (full), and the reserved code 2'b11 treated as full, drive the whole word on the pins for all four cycles. The trace clock is low in cycles 0 and 3 and high in cycles 1 and 2.
- R4: Mode code 2'b01 (split) drives word bits [W/2-1:0] on pins [W/2-1:0] in cycles 0 and 1, and word bits [W-1:W/2] on those same pins in cycles 2 and 3. Pins [W-1:W/2] stay zero. The trace clock follows the same pattern as R3, so its rising edge marks the lower half and its falling edge marks the upper half.
- R5: Mode code 2'b10 (half-rate clock) drives the whole word for all four cycles. The trace clock changes only at the start of cycle 2, toggling once per frame, which gives an 8-cycle clock period and one word per clock edge.
- R6: A frame whose sampled valid flag is low drives all-zero data, and the trace clock keeps its pattern for the mode.
- R7: Changes to the word, the valid flag or the mode made inside a frame have no effect on the pins until they are sampled at the frame's last edge.
- R8: On entry to the half-rate-clock mode from another mode, the trace clock is low in cycles 0 and 1 of the first frame in that mode. On leaving it, the trace clock returns at once to the R3 pattern.
- R9: The data pins change only at the start of cycle 0 or cycle 2, and never at an edge of the trace clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast modelling clock, four cycles per frame |
| rst | input | 1 | Synchronous active-high reset |
| trc_word | input | TRACE_W | Full-width trace word from the source |
| trc_vld | input | 1 | Word valid flag, sampled with the word |
| trc_mode | input | 2 | Mode code: 00 full, 01 split, 10 half-rate clock, 11 full |
| pin_data | output | TRACE_W | Trace data pins |
| pin_tclk | output | 1 | Generated trace clock pin |

## Verification
The split mode is driven with words whose two halves differ: alternating bit patterns, and a word whose halves are all ones and all zeros. This shows whether the halves come out in the right order and on the right lanes, and whether the upper pins stay quiet. The full and reserved codes use distinct words, so that a stale or shifted capture stands out. A run of consecutive half-rate frames, mixed with switches into and out of that mode, separates a correct toggle once per frame from a fixed pulse pattern and from a wrong starting level. Frames with the valid flag low, and inputs changed in the middle of a frame, show whether data leaks outside the frame boundary.

// File: rtl/tps_pkg.sv
`timescale 1ns/1ps
package tps_pkg;

    typedef enum logic [1:0] {
        MODE_FULL    = 2'b00,
        MODE_SPLIT   = 2'b01,
        MODE_HALFCLK = 2'b10,
        MODE_RSVD    = 2'b11
    } tps_mode_e;

    localparam int SLOT_COUNT = 4;
    localparam int SLOT_BITS  = $clog2(SLOT_COUNT);

    typedef logic [SLOT_BITS-1:0] slot_t;

    // frame cycle landmarks
    localparam slot_t SLOT_START = slot_t'(0);
    localparam slot_t SLOT_RISE  = slot_t'(1);
    localparam slot_t SLOT_MID   = slot_t'(2);
    localparam slot_t SLOT_LAST  = slot_t'(3);

    typedef struct packed {
        logic      vld;
        tps_mode_e mode;
    } frame_ctl_t;

    localparam frame_ctl_t CTL_IDLE = '{vld: 1'b0, mode: MODE_FULL};

    // the reserved code behaves as the full mode
    function automatic tps_mode_e decode_mode(input logic [1:0] code);
        case (code)
            2'b01:   return MODE_SPLIT;
            2'b10:   return MODE_HALFCLK;
            default: return MODE_FULL;
        endcase
    endfunction

    // trace clock level for the fixed (one pulse per frame) pattern
    function automatic logic fixed_tclk(input slot_t s);
        return (s == SLOT_RISE) || (s == SLOT_MID);
    endfunction

    // the first half of the frame carries the lower half in split mode
    function automatic logic lower_phase(input slot_t s);
        return s < SLOT_MID;
    endfunction

endpackage

// File: rtl/tps_slot_ctr.sv
`timescale 1ns/1ps
module tps_slot_ctr
    import tps_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    output slot_t slot,
    output logic  frame_end
);

    slot_t slot_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_q <= SLOT_START;
        end else begin
            slot_q <= slot_q + slot_t'(1);
        end
    end

    assign slot      = slot_q;
    assign frame_end = (slot_q == SLOT_LAST);

    // R2
    slot_advance_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> slot_q == $past(slot_q) + slot_t'(1));

endmodule

// File: rtl/tps_word_hold.sv
`timescale 1ns/1ps
module tps_word_hold
    import tps_pkg::*;
#(
    parameter int TRACE_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               frame_end,
    input  logic [TRACE_W-1:0] in_word,
    input  logic               in_vld,
    input  logic [1:0]         in_mode,
    output logic [TRACE_W-1:0] hold_word,
    output frame_ctl_t         ctl
);

    logic [TRACE_W-1:0] word_q;
    frame_ctl_t         ctl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q <= '0;
            ctl_q  <= CTL_IDLE;
        end else if (frame_end) begin
            word_q    <= in_word;
            ctl_q.vld  <= in_vld;
            ctl_q.mode <= decode_mode(in_mode);
        end
    end

    assign hold_word = word_q;
    assign ctl       = ctl_q;

    // R7
    ctl_boundary_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(frame_end) |-> ($stable(ctl_q) && $stable(word_q)));

endmodule

// File: rtl/tps_clk_gen.sv
`timescale 1ns/1ps
module tps_clk_gen
    import tps_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  slot_t      slot,
    input  frame_ctl_t ctl,
    output logic       tclk
);

    logic half_q;
    logic in_half;

    assign in_half = (ctl.mode == MODE_HALFCLK);

    // slow clock level: parked low outside half-rate mode, flips once per frame
    always_ff @(posedge clk) begin
        if (rst) begin
            half_q <= 1'b0;
        end else if (!in_half) begin
            half_q <= 1'b0;
        end else if (slot == SLOT_RISE) begin
            half_q <= ~half_q;
        end
    end

    assign tclk = in_half ? half_q : fixed_tclk(slot);

    // R5
    half_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (in_half && $past(in_half) && $past(slot) != SLOT_RISE) |-> $stable(tclk));

    // R5
    half_flip_chk: assert property (@(posedge clk) disable iff (rst)
        (in_half && $past(in_half) && $past(slot) == SLOT_RISE) |-> tclk != $past(tclk));

    // R8
    half_entry_chk: assert property (@(posedge clk) disable iff (rst)
        (in_half && !$past(in_half)) |-> !tclk);

endmodule

// File: rtl/tps_lane_mux.sv
`timescale 1ns/1ps
module tps_lane_mux
    import tps_pkg::*;
#(
    parameter int TRACE_W = 16
) (
    input  slot_t              slot,
    input  logic [TRACE_W-1:0] hold_word,
    input  frame_ctl_t         ctl,
    output logic [TRACE_W-1:0] lanes
);

    localparam int HALF_W = TRACE_W / 2;

    logic [HALF_W-1:0] half_sel;

    assign half_sel = lower_phase(slot) ? hold_word[HALF_W-1:0]
                                        : hold_word[TRACE_W-1:HALF_W];

    always_comb begin
        lanes = '0;
        if (ctl.vld) begin
            if (ctl.mode == MODE_SPLIT) begin
                lanes[HALF_W-1:0] = half_sel;
            end else begin
                lanes = hold_word;
            end
        end
    end

endmodule

// File: rtl/trace_halfpin_ser.sv
`timescale 1ns/1ps
module trace_halfpin_ser
    import tps_pkg::*;
#(
    parameter int TRACE_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [TRACE_W-1:0] trc_word,
    input  logic               trc_vld,
    input  logic [1:0]         trc_mode,
    output logic [TRACE_W-1:0] pin_data,
    output logic               pin_tclk
);

    localparam int HALF_W = TRACE_W / 2;

    slot_t              slot;
    logic               frame_end;
    logic [TRACE_W-1:0] hold_word;
    frame_ctl_t         ctl;

    tps_slot_ctr u_slot (
        .clk       (clk),
        .rst       (rst),
        .slot      (slot),
        .frame_end (frame_end)
    );

    tps_word_hold #(.TRACE_W(TRACE_W)) u_hold (
        .clk       (clk),
        .rst       (rst),
        .frame_end (frame_end),
        .in_word   (trc_word),
        .in_vld    (trc_vld),
        .in_mode   (trc_mode),
        .hold_word (hold_word),
        .ctl       (ctl)
    );

    tps_clk_gen u_clk (
        .clk  (clk),
        .rst  (rst),
        .slot (slot),
        .ctl  (ctl),
        .tclk (pin_tclk)
    );

    tps_lane_mux #(.TRACE_W(TRACE_W)) u_mux (
        .slot      (slot),
        .hold_word (hold_word),
        .ctl       (ctl),
        .lanes     (pin_data)
    );

    // R9
    data_edge_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (slot == SLOT_RISE || slot == SLOT_LAST) |-> $stable(pin_data));

    // R4
    split_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl.mode == MODE_SPLIT) |-> pin_data[TRACE_W-1:HALF_W] == '0);

    // R6
    idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !ctl.vld |-> pin_data == '0);

    // R1
    frame_start_low_chk: assert property (@(posedge clk) disable iff (rst)
        (slot == SLOT_START && ctl.mode != MODE_HALFCLK) |-> !pin_tclk);

endmodule

// File: tb/trace_halfpin_ser_tb_top.sv
`timescale 1ns/1ps
module trace_halfpin_ser_tb_top;

    localparam int W = 16;
    localparam int H = W / 2;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] trc_word = '0;
    logic         trc_vld = 1'b0;
    logic [1:0]   trc_mode = 2'b00;
    logic [W-1:0] pin_data;
    logic         pin_tclk;

    int errs   = 0;
    int checks = 0;
    bit done   = 0;
    bit exp_h  = 0;   // expected slow clock level at frame start

    always #2.5 clk = ~clk;

    trace_halfpin_ser #(.TRACE_W(W)) dut_i (
        .clk      (clk),
        .rst      (rst),
        .trc_word (trc_word),
        .trc_vld  (trc_vld),
        .trc_mode (trc_mode),
        .pin_data (pin_data),
        .pin_tclk (pin_tclk)
    );

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    // Called at the negedge of frame cycle 3: drive the inputs, then check the next frame.
    // If perturb is set, the inputs are changed in cycle 1 of that frame (R7).
    task automatic frame(input logic [W-1:0] w, input logic v, input logic [1:0] m,
                         input string tag, input bit perturb);
        logic [W-1:0] ed;
        logic         et;
        logic [W-1:0] prev;
        bit half;
        bit split;
        trc_word = w;
        trc_vld  = v;
        trc_mode = m;
        half  = (m == 2'b10);
        split = (m == 2'b01);
        if (!half) exp_h = 0;
        prev = '0;
        for (int s = 0; s < 4; s++) begin
            tick();
            if (!v)         ed = '0;
            else if (split) ed = (s < 2) ? {{H{1'b0}}, w[H-1:0]} : {{H{1'b0}}, w[W-1:H]};
            else            ed = w;
            if (half) et = (s < 2) ? exp_h : ~exp_h;
            else      et = (s == 1 || s == 2);
            check({tag, " data"}, pin_data, ed);
            check({tag, " tclk"}, W'(pin_tclk), W'(et));
            if (s == 1 || s == 3) check({tag, " R9 stable"}, pin_data, prev);
            prev = pin_data;
            if (perturb && s == 1) begin
                trc_word = ~w;
                trc_vld  = ~v;
                trc_mode = half ? 2'b01 : 2'b10;
            end
        end
        if (half) exp_h = ~exp_h;
    endtask

    task automatic t_reset();
        trc_word = 16'hBEEF;
        trc_vld  = 1'b1;
        trc_mode = 2'b00;
        rst = 1'b1;
        repeat (3) tick();
        check("R1 data in reset", pin_data, '0);
        check("R1 tclk in reset", W'(pin_tclk), '0);
        rst = 1'b0;
        // still frame cycle 0 after release
        check("R1 data cycle0", pin_data, '0);
        for (int s = 1; s < 4; s++) begin
            tick();
            check("R2 no early capture", pin_data, '0);
            check("R1 tclk pattern", W'(pin_tclk), W'(s == 1 || s == 2));
        end
        frame(16'hBEEF, 1'b1, 2'b00, "R2 first capture", 0);
    endtask

    task automatic t_full();
        frame(16'h1234, 1'b1, 2'b00, "R3 full", 0);
        frame(16'hC0DE, 1'b1, 2'b11, "R3 reserved", 0);
    endtask

    task automatic t_split();
        frame(16'hA5C3, 1'b1, 2'b01, "R4 split", 0);
        frame(16'hFF00, 1'b1, 2'b01, "R4 split halves", 0);
        frame(16'h00FF, 1'b1, 2'b01, "R4 split swap", 0);
    endtask

    task automatic t_halfclk();
        frame(16'h0001, 1'b1, 2'b00, "R8 before half", 0);
        frame(16'h1111, 1'b1, 2'b10, "R8 half entry", 0);
        frame(16'h2222, 1'b1, 2'b10, "R5 half", 0);
        frame(16'h3333, 1'b1, 2'b10, "R5 half", 0);
        frame(16'h4444, 1'b1, 2'b10, "R5 half", 0);
        frame(16'h5555, 1'b1, 2'b00, "R8 half exit", 0);
    endtask

    task automatic t_idle();
        frame(16'h9999, 1'b0, 2'b00, "R6 idle full", 0);
        frame(16'h9999, 1'b0, 2'b01, "R6 idle split", 0);
        frame(16'h9999, 1'b0, 2'b10, "R6 idle half", 0);
        frame(16'h7777, 1'b1, 2'b00, "R6 resume", 0);
    endtask

    task automatic t_midchange();
        frame(16'hABCD, 1'b1, 2'b00, "R7 full perturbed", 1);
        frame(16'h5A5A, 1'b1, 2'b01, "R7 split perturbed", 1);
        frame(16'h6161, 1'b1, 2'b10, "R7 half perturbed", 1);
        frame(16'h0F0F, 1'b1, 2'b01, "R8 half to split", 0);
    endtask

    initial begin
        t_reset();
        t_full();
        t_split();
        t_halfclk();
        t_idle();
        t_midchange();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            errs++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

endmodule